// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block chooses the next fetch address every cycle. While the instruction cache is read, the current fetch address also indexes a small direct-mapped table. Each table slot remembers one branch: its full address, where it went, and a 2-bit saturating counter that records its recent direction. If the slot holds the branch being fetched and the counter leans toward taken, the fetch stage jumps to the stored target. Otherwise it falls through to the sequential address. A redirect from a later stage, raised when an earlier guess is found to be wrong, overrides both of these choices.

The table learns through an update port, which the fetch stage drives in the cycle right after a prediction. A later check does not wait for the branch to resolve before changing the table. If the slot already tracks that branch, its counter steps toward the outcome and its target is refreshed. If the slot is empty or holds a different branch, the slot is rewritten. Every branch and jump presented on the port is cached this way. Decoding instructions and resolving branches happen elsewhere.

Top module: `btb_predictor`

## Requirements
- R1: The slot index is fetch-address bits [IDX_LSB +: log2(ENTRIES)], which is bits [2:1] by default. Branches whose indices differ are held at the same time, and an update to one does not change the prediction for the other.
- R2: A lookup hits only when the slot is valid and its stored branch address equals the whole fetch address. A different address that maps to the same slot misses.
- R3: Counter values 2'b00 and 2'b01 predict not taken, and 2'b10 and 2'b11 predict taken. `pred_hit` shows a hit, and `pred_taken` shows a hit whose counter predicts taken.
- R4: When there is no redirect and a hit predicts taken, `next_pc` equals the stored target.
- R5: When there is no redirect and the lookup misses or predicts not taken, `next_pc` equals `fetch_pc + PC_STEP`, wrapping modulo 2^ADDR_W.
- R6: When `redir_valid` is 1, `next_pc` equals `redir_pc`, whatever the lookup result. The hit and direction outputs still report the lookup.
- R7: An update whose address matches a valid slot moves that slot's counter one step toward the outcome, saturating at 2'b11 and at 2'b00, and stores the new target.
- R8: An update to an empty slot, or to a slot holding another branch, writes the new address and target. The counter restarts at 2'b00 and then takes one step for the outcome: taken gives 2'b01 and not taken gives 2'b00.
- R9: An update takes effect at the clock edge that ends its cycle. A lookup in the same cycle sees the table as it was before that update, and with no update the table does not change.
- R10: A low `rst_n` at a clock edge clears every valid bit, so all later lookups miss until a new update is made.
- R11: `pred_taken` is never 1 while `pred_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| redir_valid | input | 1 | Correction from a later stage |
| redir_pc | input | ADDR_W | Correction address |
| upd_valid | input | 1 | Table update this cycle |
| upd_pc | input | ADDR_W | Address of the branch being recorded |
| upd_target | input | ADDR_W | Target of the branch being recorded |
| upd_taken | input | 1 | Direction of the branch being recorded |
| next_pc | output | ADDR_W | Chosen next fetch address |
| pred_hit | output | 1 | Lookup found the branch |
| pred_taken | output | 1 | Lookup found the branch and predicts taken |

## Verification
The bench builds the block with ADDR_W = 8, ENTRIES = 4, IDX_LSB = 1 and PC_STEP = 1. With 8-bit addresses, aliasing pairs such as 0x04 and 0x0C are easy to pick by hand, and address 0xFF shows the sequential wrap to 0x00. With four slots, one slot can be walked through every counter value, including both saturation points, while a second slot stays untouched, and the redirect can be raised against a taken hit.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'b00;
    localparam ctr_t CTR_MAX   = 2'b11;

    // One saturating step toward the observed direction.
    function automatic ctr_t ctr_step(ctr_t cur, logic taken);
        ctr_t res;
        if (taken) begin
            res = (cur == CTR_MAX) ? cur : cur + 2'd1;
        end else begin
            res = (cur == CTR_RESET) ? cur : cur - 2'd1;
        end
        return res;
    endfunction

    // Upper half of the counter range means taken.
    function automatic logic ctr_taken(ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              upd_valid,
    input  logic [ADDR_W-1:0]                 upd_pc,
    input  logic [ADDR_W-1:0]                 upd_target,
    input  logic                              upd_taken,
    output logic [ENTRIES-1:0]                vld_vec,
    output logic [ENTRIES-1:0][ADDR_W-1:0]    tag_vec,
    output logic [ENTRIES-1:0][ADDR_W-1:0]    tgt_vec,
    output logic [ENTRIES-1:0][1:0]           ctr_vec
);
    import btb_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] tag;
        logic [ADDR_W-1:0] tgt;
        ctr_t              ctr;
    } slot_t;

    logic [IDX_W-1:0] upd_idx;
    assign upd_idx = upd_pc[IDX_LSB +: IDX_W];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        slot_t slot_d;
        slot_t slot_q;
        logic  sel;
        logic  same;

        assign sel  = upd_valid && (upd_idx == IDX_W'(g));
        assign same = slot_q.vld && (slot_q.tag == upd_pc);

        always_comb begin
            slot_d = slot_q;
            if (sel) begin
                slot_d.tgt = upd_target;
                if (same) begin
                    slot_d.ctr = ctr_step(slot_q.ctr, upd_taken);
                end else begin
                    slot_d.vld = 1'b1;
                    slot_d.tag = upd_pc;
                    slot_d.ctr = ctr_step(CTR_RESET, upd_taken);
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign vld_vec[g] = slot_q.vld;
        assign tag_vec[g] = slot_q.tag;
        assign tgt_vec[g] = slot_q.tgt;
        assign ctr_vec[g] = slot_q.ctr;
    end

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 1
) (
    input  logic [ADDR_W-1:0]              fetch_pc,
    input  logic [ENTRIES-1:0]             vld_vec,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_vec,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tgt_vec,
    input  logic [ENTRIES-1:0][1:0]        ctr_vec,
    output logic                           hit,
    output logic                           taken,
    output logic [ADDR_W-1:0]              target
);
    import btb_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] idx;
    assign idx = fetch_pc[IDX_LSB +: IDX_W];

    always_comb begin
        hit    = vld_vec[idx] && (tag_vec[idx] == fetch_pc);
        taken  = hit && ctr_taken(ctr_vec[idx]);
        target = tgt_vec[idx];
    end

endmodule

// File: rtl/btb_nextpc.sv
module btb_nextpc #(
    parameter int ADDR_W  = 32,
    parameter int PC_STEP = 1
) (
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              taken,
    input  logic [ADDR_W-1:0] target,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_pc,
    output logic [ADDR_W-1:0] next_pc
);
    logic [ADDR_W-1:0] seq_pc;
    assign seq_pc = fetch_pc + ADDR_W'(PC_STEP);

    always_comb begin
        if (redir_valid) begin
            next_pc = redir_pc;
        end else if (taken) begin
            next_pc = target;
        end else begin
            next_pc = seq_pc;
        end
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 1,
    parameter int PC_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pred_hit,
    output logic              pred_taken
);
    logic [ENTRIES-1:0]             vld_vec;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_vec;
    logic [ENTRIES-1:0][ADDR_W-1:0] tgt_vec;
    logic [ENTRIES-1:0][1:0]        ctr_vec;
    logic [ADDR_W-1:0]              lkp_target;

    btb_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_target (upd_target),
        .upd_taken  (upd_taken),
        .vld_vec    (vld_vec),
        .tag_vec    (tag_vec),
        .tgt_vec    (tgt_vec),
        .ctr_vec    (ctr_vec)
    );

    btb_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_lookup (
        .fetch_pc (fetch_pc),
        .vld_vec  (vld_vec),
        .tag_vec  (tag_vec),
        .tgt_vec  (tgt_vec),
        .ctr_vec  (ctr_vec),
        .hit      (pred_hit),
        .taken    (pred_taken),
        .target   (lkp_target)
    );

    btb_nextpc #(.ADDR_W(ADDR_W), .PC_STEP(PC_STEP)) u_nextpc (
        .fetch_pc    (fetch_pc),
        .taken       (pred_taken),
        .target      (lkp_target),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .next_pc     (next_pc)
    );

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 32,
    parameter int PC_STEP = 1
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [ADDR_W-1:0]                 fetch_pc,
    input logic                              redir_valid,
    input logic [ADDR_W-1:0]                 redir_pc,
    input logic                              upd_valid,
    input logic [ADDR_W-1:0]                 upd_pc,
    input logic                              upd_taken,
    input logic [ADDR_W-1:0]                 next_pc,
    input logic                              pred_hit,
    input logic                              pred_taken,
    input logic [ENTRIES-1:0]                vld_vec,
    input logic [ENTRIES-1:0][ADDR_W-1:0]    tag_vec,
    input logic [ENTRIES-1:0][1:0]           ctr_vec
);
    assert_redirect_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> next_pc == redir_pc);

    assert_fall_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && !pred_taken) |-> next_pc == fetch_pc + ADDR_W'(PC_STEP));

    assert_taken_needs_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);

    assert_quiet_table_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(vld_vec) && $stable(tag_vec) && $stable(ctr_vec)));

    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> vld_vec == '0);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_vec[g] && $past(vld_vec[g]) && tag_vec[g] == $past(tag_vec[g]))
            |-> (ctr_vec[g] == $past(ctr_vec[g])
                 || (ctr_vec[g] == 2'($past(ctr_vec[g]) + 2'd1) && $past(ctr_vec[g]) != 2'b11)
                 || (ctr_vec[g] == 2'($past(ctr_vec[g]) - 2'd1) && $past(ctr_vec[g]) != 2'b00)));

        assert_sat_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_valid && upd_taken && vld_vec[g] && upd_pc == tag_vec[g] && ctr_vec[g] == 2'b11)
            |=> ctr_vec[g] == 2'b11);

        assert_sat_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_valid && !upd_taken && vld_vec[g] && upd_pc == tag_vec[g] && ctr_vec[g] == 2'b00)
            |=> ctr_vec[g] == 2'b00);
    end

endmodule

bind btb_predictor btb_predictor_chk #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .PC_STEP (PC_STEP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_pc    (fetch_pc),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .upd_valid   (upd_valid),
    .upd_pc      (upd_pc),
    .upd_taken   (upd_taken),
    .next_pc     (next_pc),
    .pred_hit    (pred_hit),
    .pred_taken  (pred_taken),
    .vld_vec     (vld_vec),
    .tag_vec     (tag_vec),
    .ctr_vec     (ctr_vec)
);

// File: tb/test_btb_predictor.sv
module test_btb_predictor;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          redir_valid = 1'b0;
    logic [AW-1:0] redir_pc = '0;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] upd_target = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] next_pc;
    logic          pred_hit;
    logic          pred_taken;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    btb_predictor #(.ENTRIES(4), .ADDR_W(AW), .IDX_LSB(1), .PC_STEP(1)) i_btb_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .redir_valid(redir_valid), .redir_pc(redir_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken),
        .next_pc(next_pc), .pred_hit(pred_hit), .pred_taken(pred_taken)
    );

    typedef struct packed {
        logic [7:0] pc;
        logic       rv;
        logic [7:0] rpc;
        logic       uv;
        logic [7:0] upc;
        logic [7:0] utg;
        logic       ut;
        logic [7:0] enx;
        logic       eh;
        logic       et;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{8'h04, 1'b0, 8'h00, 1'b1, 8'h04, 8'h20, 1'b1, 8'h05, 1'b0, 1'b0}, // R8 alloc ->01, R9 old view
        '{8'h04, 1'b0, 8'h00, 1'b1, 8'h04, 8'h20, 1'b1, 8'h05, 1'b1, 1'b0}, // R3 01 NT, R7 ->10
        '{8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h20, 1'b1, 1'b1}, // R4
        '{8'h04, 1'b0, 8'h00, 1'b1, 8'h04, 8'h20, 1'b1, 8'h20, 1'b1, 1'b1}, // ->11
        '{8'h04, 1'b0, 8'h00, 1'b1, 8'h04, 8'h20, 1'b1, 8'h20, 1'b1, 1'b1}, // R7 saturate high
        '{8'h04, 1'b0, 8'h00, 1'b1, 8'h04, 8'h20, 1'b0, 8'h20, 1'b1, 1'b1}, // still 11, ->10
        '{8'h04, 1'b0, 8'h00, 1'b1, 8'h04, 8'h20, 1'b0, 8'h20, 1'b1, 1'b1}, // 10 T, ->01
        '{8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h05, 1'b1, 1'b0}, // 01 NT
        '{8'h04, 1'b1, 8'h33, 1'b1, 8'h0C, 8'h40, 1'b1, 8'h33, 1'b1, 1'b0}, // R6, R8 replace
        '{8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h05, 1'b0, 1'b0}, // R2 alias miss
        '{8'h0C, 1'b0, 8'h00, 1'b1, 8'h0C, 8'h40, 1'b1, 8'h0D, 1'b1, 1'b0}, // new slot 01
        '{8'h0C, 1'b1, 8'h77, 1'b0, 8'h00, 8'h00, 1'b0, 8'h77, 1'b1, 1'b1}, // R6 over taken hit
        '{8'h0C, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h40, 1'b1, 1'b1}, // R4
        '{8'h0A, 1'b0, 8'h00, 1'b1, 8'h0A, 8'h50, 1'b0, 8'h0B, 1'b0, 1'b0}, // R8 alloc NT ->00
        '{8'h0A, 1'b0, 8'h00, 1'b1, 8'h0A, 8'h50, 1'b0, 8'h0B, 1'b1, 1'b0}, // R7 saturate low
        '{8'h0A, 1'b0, 8'h00, 1'b1, 8'h0A, 8'h50, 1'b1, 8'h0B, 1'b1, 1'b0}, // 00 ->01
        '{8'h0A, 1'b0, 8'h00, 1'b1, 8'h0A, 8'h50, 1'b1, 8'h0B, 1'b1, 1'b0}, // 01 ->10
        '{8'h0A, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h50, 1'b1, 1'b1}, // R1 slot 1
        '{8'h0C, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h40, 1'b1, 1'b1}, // R1 slot 2 intact
        '{8'hFF, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0}  // R5 wrap
    };

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(logic [7:0] pc, logic rv, logic [7:0] rpc,
                         logic uv, logic [7:0] upc, logic [7:0] utg, logic ut);
        @(negedge clk);
        fetch_pc = pc; redir_valid = rv; redir_pc = rpc;
        upd_valid = uv; upd_pc = upc; upd_target = utg; upd_taken = ut;
        #1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        // R10: reset state, every lookup misses
        apply(8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        check("R10 hit in reset", int'(pred_hit), 0);
        check("R5 seq in reset", int'(next_pc), 8'h05);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].pc, VECS[k].rv, VECS[k].rpc, VECS[k].uv,
                  VECS[k].upc, VECS[k].utg, VECS[k].ut);
            if (VECS[k].rv)      check("R6 next_pc", int'(next_pc), int'(VECS[k].enx));
            else if (VECS[k].et) check("R4 next_pc", int'(next_pc), int'(VECS[k].enx));
            else                 check("R5 next_pc", int'(next_pc), int'(VECS[k].enx));
            check("R2 pred_hit", int'(pred_hit), int'(VECS[k].eh));
            check("R3 pred_taken", int'(pred_taken), int'(VECS[k].et));
            check("R11 taken implies hit", int'(pred_taken && !pred_hit), 0);
        end

        // R9: update and lookup of a fresh slot in the same cycle
        apply(8'h06, 1'b0, 8'h00, 1'b1, 8'h06, 8'h60, 1'b1);
        check("R9 same-cycle lookup misses", int'(pred_hit), 0);
        apply(8'h06, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        check("R9 visible next cycle", int'(pred_hit), 1);
        check("R8 counter 01 not taken", int'(next_pc), 8'h07);

        // R8: replacing a taken slot restarts its counter
        apply(8'h0A, 1'b0, 8'h00, 1'b1, 8'h04, 8'h22, 1'b1);
        check("R1 other slot taken", int'(next_pc), 8'h50);
        apply(8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        check("R8 restarted counter", int'(pred_taken), 0);
        check("R8 new tag hits", int'(pred_hit), 1);
        apply(8'h0C, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        check("R2 evicted branch misses", int'(pred_hit), 0);

        // R7: a matching update refreshes the target
        apply(8'h04, 1'b0, 8'h00, 1'b1, 8'h04, 8'h2A, 1'b1);
        apply(8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        check("R7 new target used", int'(next_pc), 8'h2A);

        // R10: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(8'h0A, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        check("R10 slot 1 cleared", int'(pred_hit), 0);
        check("R10 sequential after reset", int'(next_pc), 8'h0B);
        apply(8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        check("R10 slot 2 cleared", int'(pred_hit), 0);

        finish_run();
    end

endmodule